// File: doc/BRIEF.md
# Burst Column Address Sequencer

The sequencer produces one column address per clock for a memory burst. A column command loads a start column, a length code and an ordering bit. From the next cycle on, the block presents the beats of the burst on `col_o` with `valid_o` high. A fixed-length burst keeps the column bits above the burst window and walks the bits inside the window. It walks them either by counting with wraparound (sequential) or by XOR of the start bits with the beat index (interleaved). A full-page burst counts through every column of the row and keeps going until it is stopped or replaced.

The data path uses the outputs as the column of each transfer. `last_o` marks the final beat of a fixed-length burst. A stop input ends the burst early. A fresh column command given on any cycle drops the running burst and begins a new one.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `valid_o` and `last_o` are low.
- R2: When `start_i` is high at a clock edge, from that edge `valid_o` is high and `col_o` equals `start_col_i`. `len_code_i` and `ilv_i` are captured at the same edge.
- R3: A `len_code_i` with bit 2 clear gives 2^`len_code_i[1:0]` beats (1, 2, 4 or 8). A code with bit 2 set selects full-page length.
- R4: With `ilv_i`=0 and a fixed length L, beat k carries the start column's low log2(L) bits plus k modulo L. The upper bits equal those of the start column.
- R5: With `ilv_i`=1 and a fixed length L, beat k carries the start column's low log2(L) bits XOR k. The upper bits are unchanged.
- R6: `last_o` is high exactly on the final beat of a fixed-length burst. Unless `start_i` is high on that beat, `valid_o` is low from the next cycle.
- R7: A full-page burst steps `col_o` up by one each cycle, modulo 512. `last_o` never rises during it, and it runs until stopped or restarted.
- R8: Full-page length with `ilv_i`=1 behaves exactly as sequential full-page.
- R9: `stop_i` high at an edge without `start_i` makes `valid_o` low from that edge. `stop_i` while idle has no visible effect.
- R10: `start_i` during a running burst restarts at the new column from the next cycle. It overrides a `stop_i` given at the same edge.
- R11: A length-1 burst shows one valid beat, with `last_o` high on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command: begin a burst |
| start_col_i | input | 9 | Start column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Start columns are chosen with nonzero low bits, so that sequential wraparound inside the window is visible and cannot be confused with interleaved XOR. The high bits are also set, so a carry leaking above the window would show. A full-page burst started near column 511 separates modulo-512 wrap from a window-limited count. The same burst with the interleave bit set confirms that ordering is ignored in that mode. Stop and restart are driven at the first, middle and last beat and while idle, which separates command priority from the natural end of a burst. Random mixes of all inputs are then compared cycle by cycle with a bench model.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int CODE_W = 3;
  localparam int FIX_LOG_MAX = 3;

  typedef struct packed {
    logic       full;
    logic [1:0] lg;
    logic       ilv;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_cfg(input logic [CODE_W-1:0] code, input logic ilv);
    burst_cfg_t c;
    c.full = code[2];
    c.lg   = code[1:0];
    c.ilv  = ilv;
    return c;
  endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  burst_cfg_t       cfg,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic             last_beat
);

  function automatic logic [COL_W-1:0] final_idx(input logic [1:0] lg);
    return COL_W'((1 << lg) - 1);
  endfunction

  logic end_now;

  assign last_beat = active && !cfg.full && (beat == final_idx(cfg.lg));
  assign end_now   = active && (stop || last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (end_now) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (active) begin
      beat   <= beat + 1'b1;
    end
  end

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !active);
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !active);
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && beat == '0));

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mix;

  assign sum = base + beat;
  assign mix = base ^ beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < FIX_LOG_MAX) begin : g_win
      logic in_win;
      assign in_win = cfg.lg > 2'(i);
      assign col[i] = cfg.full ? sum[i] :
                      in_win   ? (cfg.ilv ? mix[i] : sum[i]) : base[i];
    end else begin : g_up
      assign col[i] = cfg.full ? sum[i] : base[i];
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  function automatic logic [COL_W-1:0] win_mask(input logic [1:0] lg);
    return COL_W'((1 << lg) - 1);
  endfunction

  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic             active;
  logic [COL_W-1:0] beat;
  logic             last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (start_i) begin
      cfg_q  <= decode_cfg(len_code_i, ilv_i);
      base_q <= start_col_i;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start_i), .stop(stop_i),
    .cfg(cfg_q), .active(active), .beat(beat), .last_beat(last_beat)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base(base_q), .beat(beat), .cfg(cfg_q), .col(col_o)
  );

  assign valid_o = active;
  assign last_o  = last_beat;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (!valid_o && !last_o));
  a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
  a_r4_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !cfg_q.full && !start_i && !stop_i && !last_o) |=>
      (valid_o && ((col_o ^ $past(col_o)) & ~win_mask(cfg_q.lg)) == '0));
  a_r7_fp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_q.full && !cfg_q.ilv && !start_i && !stop_i) |=>
      (valid_o && col_o == $past(col_o) + 1'b1));
  a_r8_fp_ilv_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_q.full && cfg_q.ilv && !start_i && !stop_i) |=>
      (valid_o && col_o == $past(col_o) + 1'b1));
  a_r7_fp_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_q.full) |-> !last_o);
  a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_code_i == 3'd0) |=> (valid_o && last_o));

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // Bench model: len 0 means full page
  bit m_act = 0;
  int m_base = 0, m_beat = 0, m_len = 1;
  bit m_ilv = 0;

  function automatic int exp_col(int base, int k, int len, bit ilv);
    int low, up;
    if (len == 0) return (base + k) % 512;
    low = base % len;
    up  = base - low;
    if (ilv) return up + (low ^ k);
    return up + ((low + k) % len);
  endfunction

  function automatic bit exp_last();
    return m_act && m_len != 0 && m_beat == m_len - 1;
  endfunction

  function automatic string auto_tag();
    if (!m_act) return "R9";
    if (m_len == 0) return m_ilv ? "R8" : "R7";
    if (m_len == 1) return "R11";
    if (exp_last()) return "R6";
    if (m_beat == 0) return "R2";
    return m_ilv ? "R5" : "R4";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_act = 0;
    else if (start_i) begin
      m_act = 1; m_beat = 0; m_base = start_col_i; m_ilv = ilv_i;
      m_len = len_code_i[2] ? 0 : (1 << len_code_i[1:0]);
    end else if (m_act && (stop_i || exp_last())) m_act = 0;
    else if (m_act) m_beat = (m_beat + 1) % 512;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    string t;
    @(negedge clk);
    t = auto_tag();
    chk(t, valid_o, m_act);
    chk(t, last_o, exp_last());
    if (m_act) chk(t, col_o, exp_col(m_base, m_beat, m_len, m_ilv));
  endtask

  task automatic go(logic [8:0] c, logic [2:0] code, logic il);
    start_i = 1; start_col_i = c; len_code_i = code; ilv_i = il;
    step();
    start_i = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1", valid_o, 0);
    chk("R1", last_o, 0);
    rst_n = 1;
    step();
    chk("R1", valid_o, 0);

    // R3: beat counts per length code
    for (int code = 0; code < 4; code++) begin
      go(9'h1F5, 3'(code), 1'b0);
      n = valid_o ? 1 : 0;
      chk("R2", col_o, 9'h1F5);
      for (int k = 0; k < 10; k++) begin step(); if (valid_o) n++; end
      chk("R3", n, 1 << code);
    end

    // R5: interleaved 8 from 0x0A6, third beat 0x0A4
    go(9'h0A6, 3'd3, 1'b1);
    step(); step();
    chk("R5", col_o, 9'h0A4);
    repeat (8) step();

    // R7/R8: full page with interleave bit set, wraps past 511
    go(9'h1FE, 3'd7, 1'b1);
    step(); step();
    chk("R8", col_o, 9'h000);
    n = 0;
    for (int k = 0; k < 600; k++) begin step(); if (last_o) n++; end
    chk("R7", n, 0);
    chk("R7", valid_o, 1);
    stop_i = 1; step(); stop_i = 0;
    chk("R9", valid_o, 0);

    // R9: stop while idle
    stop_i = 1; step(); stop_i = 0; step();
    chk("R9", valid_o, 0);

    // R9: stop on first beat of a 4-beat burst
    go(9'h033, 3'd2, 1'b0);
    stop_i = 1; step(); stop_i = 0;
    chk("R9", valid_o, 0);

    // R10: restart with simultaneous stop mid-burst
    go(9'h010, 3'd3, 1'b0);
    step(); step();
    stop_i = 1; go(9'h123, 3'd1, 1'b1); stop_i = 0;
    chk("R10", valid_o, 1);
    chk("R10", col_o, 9'h123);
    step();
    chk("R10", col_o, 9'h122);
    chk("R6", last_o, 1);
    step();

    // R10: restart on the last beat
    go(9'h0F0, 3'd1, 1'b0);
    step();
    go(9'h077, 3'd0, 1'b0);
    chk("R11", last_o, 1);
    chk("R10", col_o, 9'h077);
    step();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      start_i     = ($urandom % 8) == 0;
      stop_i      = ($urandom % 16) == 0;
      start_col_i = 9'($urandom);
      len_code_i  = (($urandom % 6) == 0) ? 3'd7 : 3'($urandom % 4);
      ilv_i       = 1'($urandom);
      step();
    end
    start_i = 0; stop_i = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule